// File: doc/BRIEF.md
# Address-Region Security Filter

This block decides, for every memory access address presented to it, whether that address belongs to secure-only memory, and flags a non-secure request that targets such memory. Memory is divided into 1 MB units. Eight programmable windows each have a lower and an upper megabyte bound, and both bounds are inclusive. One control word holds an enable bit for each window, an enable for all memory that lies outside every window, and a global bypass bit that marks the whole memory non-secure.

Software programs the bounds and the control word through a 32-bit register write port. In that port the upper half-word is a per-bit write mask for the lower half-word. The access check is purely combinational, so `secure_req` and `deny` follow the address in the same cycle. The access side carries no data and never stalls, so there is no ready signal and no back-pressure: the surrounding interconnect samples `deny` in the cycle it presents `acc_valid`. The bus protocol and error responses belong to the enclosing fabric.

Top module: `addr_sec_filter`

## Requirements
- R1: After reset every bound register reads 0, the control register (index 16) reads 0x0000_0200 (all enables 0, bypass bit 9 = 1), and every address is reported non-secure.
- R2: A write to index k updates only those bits of the stored 16-bit value whose mask bit (wr_data bit 16+j for bit j) is 1. Bits with a 0 mask keep their old value. The new value appears on the read port in the cycle after the write edge.
- R3: Reads return the stored value in bits 15:0 and zeros in bits 31:16. Writes to indices 17 to 31 change no register, and reads of those indices return 0.
- R4: Index n (0 to 7) holds the lower megabyte of window n and index n+8 holds its upper megabyte. An address whose bits 31:20 lie between them, both ends included, is in window n. With both bounds 0 the window is addresses 0x0 to 0xFFFFF.
- R5: A window whose lower bound exceeds its upper bound contains no address.
- R6: Control bits 0 to 7 make windows 0 to 7 secure. An address is secure when it lies in at least one enabled window.
- R7: Control bit 8 makes secure every address that lies in no window at all.
- R8: An address that lies in a window whose enable is 0, and in no enabled window, is non-secure even when bit 8 is 1.
- R9: When control bit 9 is 1, `secure_req` is 0 for every address, whatever the other enables say.
- R10: `deny` is 1 exactly when `acc_valid`, `acc_nonsec` and the secure decision for `acc_addr` are all 1, in the same cycle. A secure request (`acc_nonsec`=0) is never denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index for the write |
| wr_data | input | 32 | Bits 31:16 are the write mask, bits 15:0 the value |
| rd_idx | input | 5 | Register index for the read |
| rd_data | output | 32 | Stored value zero-extended, or 0 for an unused index |
| acc_valid | input | 1 | An access address is being presented |
| acc_addr | input | 32 | Byte address under test |
| acc_nonsec | input | 1 | The requester is non-secure |
| secure_req | output | 1 | The address belongs to secure-only memory |
| deny | output | 1 | A non-secure request targets secure memory |

## Verification
The bench builds the block with its defaults: a 32-bit address, 1 MB granularity and eight windows. With these values the megabyte index of the address is 12 bits wide and a full 17-register map is present. That makes the inclusive upper bound, the single-megabyte window at address zero, an inverted window, the unused indices 17 to 31 and the interplay of the leftover and bypass bits all reachable with short directed writes.

// File: rtl/sec_filt_pkg.sv
package sec_filt_pkg;
  localparam int HALF_W   = 16;
  localparam int NUM_RGN  = 8;
  localparam int REG_CNT  = 2 * NUM_RGN + 1;
  localparam int CTL_IDX  = 2 * NUM_RGN;
  localparam int IDX_W    = $clog2(REG_CNT);
  localparam int LEFT_BIT = NUM_RGN;
  localparam int BYP_BIT  = NUM_RGN + 1;

  typedef logic [HALF_W-1:0] half_t;

  localparam half_t CTL_RST = half_t'(1) << BYP_BIT;
endpackage

// File: rtl/sec_regfile.sv
module sec_regfile
  import sec_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  output half_t            lo_bnd [NUM_RGN],
  output half_t            hi_bnd [NUM_RGN],
  output half_t            ctl
);
  half_t regs [REG_CNT];
  half_t wmask;
  half_t wval;

  assign wmask = wr_data[31:16];
  assign wval  = wr_data[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < REG_CNT; k++)
        regs[k] <= (k == CTL_IDX) ? CTL_RST : '0;
    end else if (wr_en && (int'(wr_idx) < REG_CNT)) begin
      regs[wr_idx] <= (regs[wr_idx] & ~wmask) | (wval & wmask);
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < REG_CNT)
      rd_data = {16'h0000, regs[rd_idx]};
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_bnd
    assign lo_bnd[g] = regs[g];
    assign hi_bnd[g] = regs[g + NUM_RGN];
  end
  assign ctl = regs[CTL_IDX];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_chk
    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_idx) == g)) |=>
        (((regs[g] ^ $past(regs[g])) & ~$past(wr_data[31:16])) == '0)) // R2
      else $error("masked bits changed");
    AST_OTHER_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (int'(wr_idx) != g)) |=> $stable(regs[g])) // R3
      else $error("register changed without a write to it");
  end
endmodule

// File: rtl/sec_window_match.sv
module sec_window_match
  import sec_filt_pkg::*;
#(
  parameter int MB_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MB_W-1:0] mb_idx,
  input  half_t           lo_bnd [NUM_RGN],
  input  half_t           hi_bnd [NUM_RGN],
  output logic [NUM_RGN-1:0] hit
);
  half_t mb_ext;
  assign mb_ext = half_t'(mb_idx);

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
    logic ordered;
    assign ordered = (lo_bnd[g] <= hi_bnd[g]);
    assign hit[g]  = ordered && (mb_ext >= lo_bnd[g]) && (mb_ext <= hi_bnd[g]);

    AST_INVERTED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_bnd[g] > hi_bnd[g]) |-> !hit[g]) // R5
      else $error("inverted window reported a hit");
  end
endmodule

// File: rtl/sec_decide.sv
module sec_decide
  import sec_filt_pkg::*;
(
  input  logic [NUM_RGN-1:0] hit,
  input  half_t              ctl,
  output logic               secure
);
  logic in_any;
  logic en_hit;

  assign in_any = |hit;
  assign en_hit = |(hit & ctl[NUM_RGN-1:0]);
  assign secure = !ctl[BYP_BIT] && (en_hit || (!in_any && ctl[LEFT_BIT]));
endmodule

// File: rtl/addr_sec_filter.sv
module addr_sec_filter
  import sec_filt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MB_SHIFT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [4:0]        rd_idx,
  output logic [31:0]       rd_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_nonsec,
  output logic              secure_req,
  output logic              deny
);
  localparam int MB_W = ADDR_W - MB_SHIFT;

  half_t lo_bnd [NUM_RGN];
  half_t hi_bnd [NUM_RGN];
  half_t ctl;
  logic [NUM_RGN-1:0] hit;
  logic secure;

  sec_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .lo_bnd  (lo_bnd),
    .hi_bnd  (hi_bnd),
    .ctl     (ctl)
  );

  sec_window_match #(.MB_W(MB_W)) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .mb_idx (acc_addr[ADDR_W-1:MB_SHIFT]),
    .lo_bnd (lo_bnd),
    .hi_bnd (hi_bnd),
    .hit    (hit)
  );

  sec_decide u_dec (
    .hit    (hit),
    .ctl    (ctl),
    .secure (secure)
  );

  assign secure_req = secure;
  assign deny       = acc_valid && acc_nonsec && secure;

  AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[BYP_BIT] |-> !secure_req) // R9
    else $error("secure while bypassed");
  AST_SECURE_NEVER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_nonsec) |-> !deny) // R10
    else $error("secure requester denied");
  AST_DENY_NEEDS_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> (secure_req && acc_valid)) // R10
    else $error("deny without secure target");
  AST_NO_HIT_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && !ctl[LEFT_BIT]) |-> !secure_req) // R7
    else $error("secure outside windows with leftover disabled");
endmodule

// File: tb/test_addr_sec_filter.sv
module test_addr_sec_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_nonsec = 1'b0;
  logic        secure_req;
  logic        deny;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_sec_filter i_addr_sec_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_nonsec(acc_nonsec), .secure_req(secure_req), .deny(deny)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [15:0] msk, logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = {msk, val};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, int idx, logic [31:0] exp);
    @(negedge clk);
    rd_idx = 5'(idx);
    #1 chk(tag, rd_data, exp);
  endtask

  task automatic probe(string tag, logic [31:0] a, logic exp_sec);
    @(negedge clk);
    acc_valid = 1'b1; acc_nonsec = 1'b1; acc_addr = a;
    #1 chk({tag, " secure"}, 32'(secure_req), 32'(exp_sec));
    chk({tag, " deny"}, 32'(deny), 32'(exp_sec));
  endtask

  task automatic t_reset;
    rd_chk("R1 bound0", 0, 32'h0);
    rd_chk("R1 bound15", 15, 32'h0);
    rd_chk("R1 ctl", 16, 32'h0000_0200);
    probe("R1 addr0", 32'h0000_0000, 1'b0);
  endtask

  task automatic t_masked;
    wr(3, 16'hFFFF, 16'hA5A5);
    wr(3, 16'h00F0, 16'h1234);
    rd_chk("R2 masked", 3, 32'h0000_A535);
    wr(3, 16'h0000, 16'hFFFF);
    rd_chk("R2 zero mask", 3, 32'h0000_A535);
    wr(3, 16'hFFFF, 16'h0000);
  endtask

  task automatic t_high_idx;
    wr(20, 16'hFFFF, 16'hFFFF);
    wr(31, 16'hFFFF, 16'hFFFF);
    rd_chk("R3 read 20", 20, 32'h0);
    rd_chk("R3 ctl untouched", 16, 32'h0000_0200);
    rd_chk("R3 bound untouched", 0, 32'h0);
    wr(5, 16'hFFFF, 16'hBEEF);
    rd_chk("R3 upper zero", 5, 32'h0000_BEEF);
    wr(5, 16'hFFFF, 16'h0000);
  endtask

  task automatic t_windows;
    wr(16, 16'h0200, 16'h0000);
    wr(16, 16'h0003, 16'h0003);
    wr(1, 16'hFFFF, 16'd32);
    wr(9, 16'hFFFF, 16'd47);
    probe("R4 zero window top", 32'h000F_FFFF, 1'b1);
    probe("R4 zero window next", 32'h0010_0000, 1'b0);
    probe("R4 low bound", 32'h0200_0000, 1'b1);
    probe("R4 high bound incl", 32'h02FF_FFFF, 1'b1);
    probe("R6 below window", 32'h01FF_FFFF, 1'b0);
    probe("R6 above window", 32'h0300_0000, 1'b0);
  endtask

  task automatic t_inverted;
    wr(2, 16'hFFFF, 16'd100);
    wr(10, 16'hFFFF, 16'd50);
    wr(16, 16'h0004, 16'h0004);
    probe("R5 inverted mid", 32'h04B0_0000, 1'b0);
    probe("R5 inverted lo", 32'h0640_0000, 1'b0);
  endtask

  task automatic t_leftover;
    wr(16, 16'h0100, 16'h0100);
    probe("R7 outside all", 32'h04B0_0000, 1'b1);
    probe("R7 top addr", 32'hFFFF_FFFF, 1'b1);
    wr(16, 16'h0002, 16'h0000);
    probe("R8 disabled window", 32'h0280_0000, 1'b0);
    probe("R6 enabled still", 32'h0000_0000, 1'b1);
  endtask

  task automatic t_deny;
    @(negedge clk);
    acc_valid = 1'b1; acc_nonsec = 1'b0; acc_addr = 32'h0000_0000;
    #1 chk("R10 secure requester", 32'(deny), 32'h0);
    chk("R10 secure flag", 32'(secure_req), 32'h1);
    @(negedge clk);
    acc_valid = 1'b0; acc_nonsec = 1'b1;
    #1 chk("R10 no valid", 32'(deny), 32'h0);
  endtask

  task automatic t_bypass;
    wr(16, 16'h0200, 16'h0200);
    probe("R9 bypass win0", 32'h0000_0000, 1'b0);
    probe("R9 bypass outside", 32'h04B0_0000, 1'b0);
    rd_chk("R9 ctl readback", 16, 32'h0000_0305);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked();
    t_high_idx();
    t_windows();
    t_inverted();
    t_leftover();
    t_deny();
    t_bypass();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule